// File: doc/BRIEF.md
# LPDDR5 Write-Clock Sync Sequence Generator

This block produces the write-clock waveform that a memory PHY must send around every read or write burst. It emits one 8-bit word per controller clock. The word holds the serial samples of the write clock for that controller cycle, and a downstream serializer shifts them out. Each burst gets a waveform in four parts. The clock is first held low for an enable latency plus a static time. A toggling preamble follows. The clock then toggles through the 16-beat burst, and a short postamble ends the sequence, after which the clock returns low.

The controller pulses `wr_start` or `rd_start` in the cycle its column command goes out. The latency counts for reads and writes arrive on separate pins. They are computed elsewhere and sampled when a sequence is accepted. The `ratio4` pin selects a write-clock to command-clock ratio of 4:1 (high) or 2:1 (low). A training mode, enabled by `lvl_en`, makes each `lvl_strobe` pulse produce a fixed run of low words followed by toggling words.

The output is a free-running word stream with no valid/ready handshake. A word is produced every cycle and cannot be back-pressured. Every other pin is plain control.

Top module: `lp5_wclk_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `wclk_word` is 8'h00.
- R2: At 2:1 only bits [3:0] carry samples and bits [7:4] are 0. At 4:1 all 8 bits carry samples. The most significant used bit goes out first. A full-rate toggle word is 4'hA at 2:1 and 8'hAA at 4:1.
- R3: A start is sampled at a clock edge, and the sequence begins with the word in the next cycle. It consists of L = en_lat + hold_lat zero words, then P = pre_len preamble words, then a burst of 4 toggle words at 2:1 or 2 at 4:1.
- R4: At 4:1 the first preamble word is the half-rate word 8'hCC and the remaining preamble words are 8'hAA. At 2:1 every preamble word is 4'hA.
- R5: The postamble is 4'hA followed by 4'h8 at 2:1, or a single 8'hA8 at 4:1. The output then returns to 8'h00.
- R6: `wr_start` uses the wr_* counts and `rd_start` uses the rd_* counts. When both are high, the write counts win.
- R7: When L is zero the low phase is skipped, and when P is zero the preamble is skipped.
- R8: A start sampled during the burst or postamble restarts a full burst of toggle words from the next cycle. A start sampled during the low or preamble phase adds one extra burst length to the toggling.
- R9: While `lvl_en` is high, a `lvl_strobe` accepted with no sequence running yields 3 words of 8'h00, then 4 full-rate toggle words, then 8'h00. Strobes are ignored while `lvl_en` is low or while a sequence is running. Starts are ignored while `lvl_en` is high.
- R10: `ratio4` and the count inputs are captured when a sequence is accepted. Changing them later has no effect on that sequence.
- R11: A start that comes after the output has returned to idle gets a complete fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio4 | input | 1 | 1 selects 4:1, 0 selects 2:1 |
| wr_start | input | 1 | Write column command issued this cycle |
| rd_start | input | 1 | Read column command issued this cycle |
| wr_en_lat | input | CNT_W | Write enable latency, in cycles |
| wr_hold_lat | input | CNT_W | Write static-low time, in cycles |
| wr_pre_len | input | CNT_W | Write preamble length, in cycles |
| rd_en_lat | input | CNT_W | Read enable latency, in cycles |
| rd_hold_lat | input | CNT_W | Read static-low time, in cycles |
| rd_pre_len | input | CNT_W | Read preamble length, in cycles |
| lvl_en | input | 1 | Training mode enable |
| lvl_strobe | input | 1 | Training pulse request |
| wclk_word | output | 8 | Write-clock samples for this cycle |

## Verification
The bench sweeps every combination of small enable, static and preamble counts for both ratios and both command kinds, including the zero-length phases. A design that mishandled a zero count would emit a stray low word or toggle word, or would stall. Each start is followed by a flip of `ratio4` and the counts, so a design that failed to capture them would change its word pattern partway through. Retriggers land in the low, preamble and burst phases, where a wrong design would restart the preamble or cut the toggling short. The training tests also fire starts and extra strobes in the middle of a run, which a wrong design would let corrupt the fixed 3-low, 4-toggle pattern.

// File: rtl/lp5_wclk_pkg.sv
package lp5_wclk_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_PRE   = 3'd2,
    PH_BURST = 3'd3,
    PH_POST  = 3'd4,
    PH_LVLO  = 3'd5,
    PH_LVTG  = 3'd6
  } wclk_phase_e;

  // Sample words, MSB transmitted first.
  localparam logic [WORD_W-1:0] W_ZERO   = 8'h00;
  localparam logic [WORD_W-1:0] W_TOG2   = 8'h0A;
  localparam logic [WORD_W-1:0] W_TOG4   = 8'hAA;
  localparam logic [WORD_W-1:0] W_HALF4  = 8'hCC;
  localparam logic [WORD_W-1:0] W_POST2L = 8'h08;
  localparam logic [WORD_W-1:0] W_POST4  = 8'hA8;
endpackage

// File: rtl/lp5_wclk_tsel.sv
module lp5_wclk_tsel #(
  parameter int CNT_W = 4,
  localparam int CW = CNT_W + 1
) (
  input  logic             wr_start,
  input  logic [CNT_W-1:0] wr_en_lat,
  input  logic [CNT_W-1:0] wr_hold_lat,
  input  logic [CNT_W-1:0] wr_pre_len,
  input  logic [CNT_W-1:0] rd_en_lat,
  input  logic [CNT_W-1:0] rd_hold_lat,
  input  logic [CNT_W-1:0] rd_pre_len,
  output logic [CW-1:0]    sel_low,
  output logic [CNT_W-1:0] sel_pre
);
  // Write has priority over read when both start together.
  always_comb begin
    if (wr_start) begin
      sel_low = CW'(wr_en_lat) + CW'(wr_hold_lat);
      sel_pre = wr_pre_len;
    end else begin
      sel_low = CW'(rd_en_lat) + CW'(rd_hold_lat);
      sel_pre = rd_pre_len;
    end
  end
endmodule

// File: rtl/lp5_wclk_fsm.sv
module lp5_wclk_fsm
  import lp5_wclk_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int BURST_BEATS = 16,
  parameter int LVL_LOW     = 3,
  parameter int LVL_TOG     = 4,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ratio4,
  input  logic             start_any,
  input  logic             lvl_en,
  input  logic             lvl_strobe,
  input  logic [CW-1:0]    sel_low,
  input  logic [CNT_W-1:0] sel_pre,
  output wclk_phase_e      ph,
  output logic             r4_q,
  output logic             pfirst_q,
  output logic             last
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] BL2  = CW'(BURST_BEATS / 4);
  localparam logic [CW-1:0] BL4  = CW'(BURST_BEATS / 8);
  localparam logic [CW-1:0] LVLO = CW'(LVL_LOW);
  localparam logic [CW-1:0] LVTG = CW'(LVL_TOG);

  wclk_phase_e      ph_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic [CNT_W-1:0] pre_q, pre_n;
  logic             r4_n, extra_q, extra_n, pfirst_n;
  logic             go;
  logic [CW-1:0]    blen_cur, blen_new, plen_cur;

  assign go       = start_any & ~lvl_en;
  assign blen_cur = r4_q ? BL4 : BL2;
  assign blen_new = ratio4 ? BL4 : BL2;
  assign plen_cur = r4_q ? ONE : CW'(2);
  assign last     = (cnt == '0);

  always_comb begin
    ph_n     = ph;
    cnt_n    = cnt;
    r4_n     = r4_q;
    pre_n    = pre_q;
    extra_n  = extra_q;
    pfirst_n = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (lvl_en && lvl_strobe) begin
          ph_n  = PH_LVLO;
          cnt_n = LVLO - ONE;
          r4_n  = ratio4;
        end else if (go) begin
          r4_n    = ratio4;
          pre_n   = sel_pre;
          extra_n = 1'b0;
          if (sel_low != '0) begin
            ph_n  = PH_LOW;
            cnt_n = sel_low - ONE;
          end else if (sel_pre != '0) begin
            ph_n     = PH_PRE;
            cnt_n    = CW'(sel_pre) - ONE;
            pfirst_n = 1'b1;
          end else begin
            ph_n  = PH_BURST;
            cnt_n = blen_new - ONE;
          end
        end
      end
      PH_LOW: begin
        if (go) extra_n = 1'b1;
        if (!last) cnt_n = cnt - ONE;
        else if (pre_q != '0) begin
          ph_n     = PH_PRE;
          cnt_n    = CW'(pre_q) - ONE;
          pfirst_n = 1'b1;
        end else begin
          ph_n  = PH_BURST;
          cnt_n = blen_cur - ONE;
        end
      end
      PH_PRE: begin
        if (go) extra_n = 1'b1;
        if (!last) cnt_n = cnt - ONE;
        else begin
          ph_n  = PH_BURST;
          cnt_n = blen_cur - ONE;
        end
      end
      PH_BURST: begin
        if (go) cnt_n = blen_cur - ONE;
        else if (!last) cnt_n = cnt - ONE;
        else if (extra_q) begin
          cnt_n   = blen_cur - ONE;
          extra_n = 1'b0;
        end else begin
          ph_n  = PH_POST;
          cnt_n = plen_cur - ONE;
        end
      end
      PH_POST: begin
        if (go) begin
          ph_n  = PH_BURST;
          cnt_n = blen_cur - ONE;
        end else if (!last) cnt_n = cnt - ONE;
        else ph_n = PH_IDLE;
      end
      PH_LVLO: begin
        if (!last) cnt_n = cnt - ONE;
        else begin
          ph_n  = PH_LVTG;
          cnt_n = LVTG - ONE;
        end
      end
      PH_LVTG: begin
        if (!last) cnt_n = cnt - ONE;
        else ph_n = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      r4_q     <= 1'b0;
      pre_q    <= '0;
      extra_q  <= 1'b0;
      pfirst_q <= 1'b0;
    end else begin
      ph       <= ph_n;
      cnt      <= cnt_n;
      r4_q     <= r4_n;
      pre_q    <= pre_n;
      extra_q  <= extra_n;
      pfirst_q <= pfirst_n;
    end
  end

  // R8: a start during the burst reloads the full burst count
  a_r8_burst_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_BURST && go) |=> (ph == PH_BURST && cnt == blen_cur - ONE));
  // R9: an accepted strobe enters the training low phase
  a_r9_lvl_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && lvl_en && lvl_strobe) |=> (ph == PH_LVLO));
  // R9: no normal sequence starts while training is enabled
  a_r9_no_start_in_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && lvl_en) |=> (ph == PH_IDLE || ph == PH_LVLO));
  // R10: the captured ratio holds while a sequence runs
  a_r10_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> $stable(r4_q));
  // R5: the last postamble word is followed by idle unless retriggered
  a_r5_post_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_POST && last && !go) |=> (ph == PH_IDLE));
  // R8: burst counter never exceeds one burst length
  a_r8_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_BURST) |-> (cnt < blen_cur));
endmodule

// File: rtl/lp5_wclk_word.sv
module lp5_wclk_word
  import lp5_wclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wclk_phase_e       ph,
  input  logic              r4,
  input  logic              pfirst,
  input  logic              last,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] tog;
  assign tog = r4 ? W_TOG4 : W_TOG2;

  always_comb begin
    unique case (ph)
      PH_PRE:            word = (r4 && pfirst) ? W_HALF4 : tog;
      PH_BURST, PH_LVTG: word = tog;
      PH_POST:           word = r4 ? W_POST4 : (last ? W_POST2L : W_TOG2);
      default:           word = W_ZERO;
    endcase
  end

  // R1: quiet output while no sequence is active
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE || ph == PH_LOW || ph == PH_LVLO) |-> (word == W_ZERO));
  // R2: upper bits are unused at 2:1
  a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!r4) |-> (word[7:4] == 4'h0));
endmodule

// File: rtl/lp5_wclk_seq.sv
module lp5_wclk_seq
  import lp5_wclk_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int BURST_BEATS = 16,
  parameter int LVL_LOW     = 3,
  parameter int LVL_TOG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ratio4,
  input  logic              wr_start,
  input  logic              rd_start,
  input  logic [CNT_W-1:0]  wr_en_lat,
  input  logic [CNT_W-1:0]  wr_hold_lat,
  input  logic [CNT_W-1:0]  wr_pre_len,
  input  logic [CNT_W-1:0]  rd_en_lat,
  input  logic [CNT_W-1:0]  rd_hold_lat,
  input  logic [CNT_W-1:0]  rd_pre_len,
  input  logic              lvl_en,
  input  logic              lvl_strobe,
  output logic [WORD_W-1:0] wclk_word
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0]    sel_low;
  logic [CNT_W-1:0] sel_pre;
  wclk_phase_e      ph;
  logic             r4_q, pfirst_q, last;

  lp5_wclk_tsel #(.CNT_W(CNT_W)) u_tsel (
    .wr_start   (wr_start),
    .wr_en_lat  (wr_en_lat),
    .wr_hold_lat(wr_hold_lat),
    .wr_pre_len (wr_pre_len),
    .rd_en_lat  (rd_en_lat),
    .rd_hold_lat(rd_hold_lat),
    .rd_pre_len (rd_pre_len),
    .sel_low    (sel_low),
    .sel_pre    (sel_pre)
  );

  lp5_wclk_fsm #(
    .CNT_W(CNT_W), .BURST_BEATS(BURST_BEATS),
    .LVL_LOW(LVL_LOW), .LVL_TOG(LVL_TOG)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio4    (ratio4),
    .start_any (wr_start | rd_start),
    .lvl_en    (lvl_en),
    .lvl_strobe(lvl_strobe),
    .sel_low   (sel_low),
    .sel_pre   (sel_pre),
    .ph        (ph),
    .r4_q      (r4_q),
    .pfirst_q  (pfirst_q),
    .last      (last)
  );

  lp5_wclk_word u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph),
    .r4    (r4_q),
    .pfirst(pfirst_q),
    .last  (last),
    .word  (wclk_word)
  );
endmodule

// File: tb/lp5_wclk_seq_tb.sv
module lp5_wclk_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ratio4 = 1'b0, wr_start = 1'b0, rd_start = 1'b0;
  logic [CNT_W-1:0] wr_en_lat = '0, wr_hold_lat = '0, wr_pre_len = '0;
  logic [CNT_W-1:0] rd_en_lat = '0, rd_hold_lat = '0, rd_pre_len = '0;
  logic lvl_en = 1'b0, lvl_strobe = 1'b0;
  logic [7:0] wclk_word;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp5_wclk_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ratio4(ratio4),
    .wr_start(wr_start), .rd_start(rd_start),
    .wr_en_lat(wr_en_lat), .wr_hold_lat(wr_hold_lat), .wr_pre_len(wr_pre_len),
    .rd_en_lat(rd_en_lat), .rd_hold_lat(rd_hold_lat), .rd_pre_len(rd_pre_len),
    .lvl_en(lvl_en), .lvl_strobe(lvl_strobe), .wclk_word(wclk_word)
  );

  function automatic logic [7:0] tog_w(bit r4);
    return r4 ? 8'hAA : 8'h0A;
  endfunction

  // Expected word k cycles after the accepting edge (R3, R4, R5, R7).
  function automatic logic [7:0] exp_w(int k, int L, int T, int B, bit r4);
    int j;
    j = k;
    if (j < L) return 8'h00;
    j -= L;
    if (j < T) return (r4 && j == 0) ? 8'hCC : tog_w(r4);
    j -= T;
    if (j < B) return tog_w(r4);
    j -= B;
    if (r4) return (j == 0) ? 8'hA8 : 8'h00;
    if (j == 0) return 8'h0A;
    if (j == 1) return 8'h08;
    return 8'h00;
  endfunction

  task automatic check(logic [7:0] got, logic [7:0] expv, string req);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, expv, $time);
    end
  endtask

  task automatic set_counts(bit wr, int en, int st, int pr);
    if (wr) begin
      wr_en_lat = CNT_W'(en); wr_hold_lat = CNT_W'(st); wr_pre_len = CNT_W'(pr);
      rd_en_lat = 4'd7; rd_hold_lat = 4'd6; rd_pre_len = 4'd5;
    end else begin
      rd_en_lat = CNT_W'(en); rd_hold_lat = CNT_W'(st); rd_pre_len = CNT_W'(pr);
      wr_en_lat = 4'd7; wr_hold_lat = 4'd6; wr_pre_len = 4'd5;
    end
  endtask

  // One sequence; rt_k >= 0 retriggers after observing word rt_k (R8).
  task automatic run_seq(bit wr, bit both, bit r4, int en, int st, int pr,
                         int rt_k, int bsum, string req);
    int L, T, N;
    L = en + st; T = pr;
    N = L + T + bsum + (r4 ? 1 : 2) + 3;
    @(negedge clk);
    ratio4 = r4;
    set_counts(wr, en, st, pr);
    if (both) begin
      rd_en_lat = 4'd1; rd_hold_lat = 4'd0; rd_pre_len = 4'd1;
    end
    wr_start = wr | both;
    rd_start = ~wr | both;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      wr_start = 1'b0; rd_start = 1'b0;
      if (k == 0) begin
        // R10: disturb captured inputs once the sequence has been accepted
        ratio4 = ~r4;
        wr_en_lat = 4'd9; wr_hold_lat = 4'd9; wr_pre_len = 4'd9;
        rd_en_lat = 4'd9; rd_hold_lat = 4'd9; rd_pre_len = 4'd9;
      end
      check(wclk_word, exp_w(k, L, T, bsum, r4), req);
      if (k == rt_k) begin
        ratio4 = r4;
        if (wr) wr_start = 1'b1; else rd_start = 1'b1;
      end
    end
  endtask

  // R9: training strobe with starts and strobes injected mid-run
  task automatic run_lvl(bit r4);
    logic [7:0] e;
    @(negedge clk);
    lvl_en = 1'b1; ratio4 = r4; lvl_strobe = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      lvl_strobe = (k == 2);
      wr_start = (k == 4);
      if (k == 0) ratio4 = ~r4;
      e = (k >= 3 && k < 7) ? tog_w(r4) : 8'h00;
      check(wclk_word, e, "R9 training pattern");
    end
    @(negedge clk);
    lvl_strobe = 1'b0; wr_start = 1'b0;
    check(wclk_word, 8'h00, "R9 training end");
    lvl_en = 1'b0;
  endtask

  task automatic quiet_window(string req);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wr_start = 1'b0; lvl_strobe = 1'b0;
      check(wclk_word, 8'h00, req);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wclk_word, 8'h00, "R1 reset");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(wclk_word, 8'h00, "R1 idle");
    end

    // R3 R4 R5 R6 R7 R10 R11: sweep over small counts
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 2; w++)
        for (int en = 0; en < 4; en++)
          for (int st = 0; st < 3; st++)
            for (int pr = 0; pr < 4; pr++)
              run_seq(w[0], 1'b0, r[0], en, st, pr, -1, r[0] ? 2 : 4,
                      "R3/R4/R5/R7/R10/R11 sweep");

    // Larger example counts
    run_seq(1'b1, 1'b0, 1'b0, 3, 4, 4, -1, 4, "R3 write large");
    run_seq(1'b0, 1'b0, 1'b0, 5, 4, 10, -1, 4, "R3 read large");
    run_seq(1'b0, 1'b0, 1'b1, 3, 2, 5, -1, 2, "R4 read 4to1");

    // R6: write counts win when both start
    run_seq(1'b1, 1'b1, 1'b0, 2, 3, 2, -1, 4, "R6 write priority");
    run_seq(1'b1, 1'b1, 1'b1, 0, 2, 3, -1, 2, "R6 write priority 4to1");

    // R8: retriggers
    run_seq(1'b1, 1'b0, 1'b0, 1, 1, 3, 2 + 3 + 1, 1 + 1 + 4, "R8 burst retrigger");
    run_seq(1'b0, 1'b0, 1'b1, 1, 1, 3, 2 + 3, 1 + 2, "R8 burst retrigger 4to1");
    run_seq(1'b1, 1'b0, 1'b0, 2, 1, 2, 0, 8, "R8 low retrigger");
    run_seq(1'b0, 1'b0, 1'b1, 1, 0, 3, 1, 4, "R8 preamble retrigger");

    // R9: training mode
    run_lvl(1'b0);
    run_lvl(1'b1);
    @(negedge clk);
    lvl_en = 1'b0; lvl_strobe = 1'b1;
    quiet_window("R9 strobe ignored without enable");
    @(negedge clk);
    lvl_en = 1'b1; wr_start = 1'b1;
    quiet_window("R9 start ignored in training");
    lvl_en = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule